// File: doc/BRIEF.md
# Event Driven Capture Unit

This block couples a free-running counter with two capture channels and a small flag and mask bank, all driven by one external event line. The event line is conditioned first: a gate bit can block it, and a polarity bit can invert it. After that the unit watches for edges. Depending on the selected action, an edge can restart the counter, start a counter that is waiting, advance the counter by one, or copy the counter into one or both capture channels.

Measuring a signal's period and its high time takes only one input. The active edge stores the count in a period channel and restarts the counter from zero. The opposite edge stores the count in the width channel. The two channel roles can be swapped. A pulse-width-only action and a plain timestamp action are also provided. Each channel can keep the latest capture, the smallest one seen, or the largest one seen. This allows worst-case jitter to be tracked without software reading every sample.

Captured values are held registers, not a stream. They are always readable and carry no handshake, so there is no back-pressure. Control and status are plain level pins. Flag clears and mask writes are one-cycle pulses.

Top module: `evcap_unit`

## Requirements
- R1: After reset, the counter, both capture values, the flag vector, the enable mask and the interrupt output are all zero.
- R2: The conditioned event is `cfg_ev_en & (ev_in ^ cfg_ev_inv)`. A rising edge of it is the active edge and a falling edge is the opposite edge. With `cfg_ev_en` low, no edge occurs, whatever `ev_in` does.
- R3: When `cfg_run` is high and the action is 0 (off), 4, 5, 6 or 7, the counter advances by one every cycle. Advancing from all-ones wraps it to zero and sets flag bit 0 (overflow).
- R4: Action 1 (retrigger): an active edge while running loads zero, and counting proceeds from the next cycle. Action 3 (start): the counter holds until an active edge, then counts on from its held value. Lowering `cfg_run` stops the counter and re-arms the wait.
- R5: Action 2 (count): while running, the counter advances by one for each active edge only.
- R6: Action 4 (timestamp): an active edge copies the current count into every enabled channel.
- R7: Action 5: an active edge stores the count in channel 0 and, while running, restarts the counter at zero; an opposite edge stores the count in channel 1. Action 6 is the same with the channels swapped.
- R8: Action 7 (pulse width): an active edge restarts the counter while running; an opposite edge stores the count in every enabled channel.
- R9: A channel whose bit in `cfg_cap_en` (bit 0 for channel 0) is low keeps its value and never sets its capture flag.
- R10: Keep mode per channel (`cfg_cap_mode[1:0]` for channel 0, `[3:2]` for channel 1). 0 or 3 stores every capture. 1 stores a capture only if it is below the held value. 2 stores a capture only if it is above the held value. The first capture after reset is always stored.
- R11: Every capture sets the channel's flag (bit 4 for channel 0, bit 5 for channel 1). A one in `flag_clr` clears that flag. A set and a clear in the same cycle leave the flag set. Bits 2, 3, 6 and 7 always read zero.
- R12: Flag bit 1 (error) sets when a channel captures while its flag is already set and not being cleared in that same cycle.
- R13: `ien_set` and `ien_clr` set and clear mask bits at the same positions, and clear wins on a collision. `irq_o` is high when any flag is set and its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 1 | Raw event line |
| cfg_run | input | 1 | Counter enable |
| cfg_evact | input | 3 | Event action select (0..7) |
| cfg_ev_en | input | 1 | Event gate |
| cfg_ev_inv | input | 1 | Event polarity invert |
| cfg_cap_en | input | 2 | Per-channel capture enable |
| cfg_cap_mode | input | 4 | Per-channel keep mode, 2 bits each |
| flag_clr | input | 8 | Write-one-to-clear pulse for flags |
| ien_set | input | 8 | Mask set pulse |
| ien_clr | input | 8 | Mask clear pulse |
| count_o | output | CNT_W | Counter value |
| cap0_o | output | CNT_W | Channel 0 held value |
| cap1_o | output | CNT_W | Channel 1 held value |
| flags_o | output | 8 | Flag vector |
| ien_o | output | 8 | Enable mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The delicate collision is a capture landing in the same cycle as a write-one-clear of that channel's flag. The same edge also races the error rule. The bench drives the opposite edge and a `flag_clr` pulse on the same falling clock edge, so both reach the same rising edge. It then judges that the flag stays set and the error bit does not rise. The reverse case is a capture with no clear while the flag is still pending, which must raise the error bit. Overflow meeting a clear of bit 0 is exercised by the random phase and compared against a cycle model built from the requirements.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  typedef enum logic [2:0] {
    ACT_OFF    = 3'd0,
    ACT_RETRIG = 3'd1,
    ACT_COUNT  = 3'd2,
    ACT_START  = 3'd3,
    ACT_STAMP  = 3'd4,
    ACT_PPW    = 3'd5,
    ACT_PWP    = 3'd6,
    ACT_PW     = 3'd7
  } evact_e;

  typedef enum logic [1:0] {
    KEEP_LAST = 2'd0,
    KEEP_MIN  = 2'd1,
    KEEP_MAX  = 2'd2,
    KEEP_ALT  = 2'd3
  } keep_e;

  localparam int          CH_N      = 2;
  localparam int          FLG_W     = 8;
  localparam int          FLG_OVF   = 0;
  localparam int          FLG_ERR   = 1;
  localparam int          FLG_CH0   = 4;
  localparam logic [7:0]  FLG_VALID = 8'h33;
endpackage

// File: rtl/evcap_event.sv
module evcap_event (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  input  logic ev_en,
  input  logic ev_inv,
  output logic rise,
  output logic fall
);
  logic ev_now;
  logic ev_q;

  assign ev_now = ev_en & (ev_in ^ ev_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= ev_now;
  end

  assign rise = ev_now & ~ev_q;
  assign fall = ~ev_now & ev_q;
endmodule

// File: rtl/evcap_counter.sv
module evcap_counter
  import evcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  evact_e           act,
  input  logic             rise,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic live_q;
  logic waits;
  logic go;
  logic restart;
  logic tick;

  assign waits   = (act == ACT_RETRIG) || (act == ACT_START);
  assign go      = run & (live_q | ~waits);
  assign restart = run & rise & ((act == ACT_RETRIG) || (act == ACT_PPW) ||
                                 (act == ACT_PWP) || (act == ACT_PW));
  assign tick    = (act == ACT_COUNT) ? (run & rise) : go;
  assign ovf     = tick & ~restart & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt    <= '0;
    end else begin
      live_q <= run & (live_q | (rise & waits));
      if (restart)   cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evcap_channel.sv
module evcap_channel
  import evcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] sample,
  output logic [CNT_W-1:0] value
);
  logic held_q;
  logic take;

  always_comb begin
    take = 1'b0;
    if (strobe) begin
      if (!held_q) begin
        take = 1'b1;
      end else begin
        case (keep_e'(mode))
          KEEP_MIN: take = (sample < value);
          KEEP_MAX: take = (sample > value);
          default:  take = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      value  <= '0;
    end else begin
      if (strobe) held_q <= 1'b1;
      if (take)   value  <= sample;
    end
  end
endmodule

// File: rtl/evcap_flags.sv
module evcap_flags
  import evcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_W-1:0] set_v,
  input  logic [FLG_W-1:0] clr_v,
  input  logic [FLG_W-1:0] mask_set,
  input  logic [FLG_W-1:0] mask_clr,
  output logic [FLG_W-1:0] flags,
  output logic [FLG_W-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= ((flags & ~clr_v) | set_v) & FLG_VALID;
      mask  <= ((mask | mask_set) & ~mask_clr) & FLG_VALID;
    end
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
  import evcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in,
  input  logic             cfg_run,
  input  logic [2:0]       cfg_evact,
  input  logic             cfg_ev_en,
  input  logic             cfg_ev_inv,
  input  logic [1:0]       cfg_cap_en,
  input  logic [3:0]       cfg_cap_mode,
  input  logic [7:0]       flag_clr,
  input  logic [7:0]       ien_set,
  input  logic [7:0]       ien_clr,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic [7:0]       flags_o,
  output logic [7:0]       ien_o,
  output logic             irq_o
);
  evact_e           act;
  logic             rise;
  logic             fall;
  logic             ovf;
  logic [CH_N-1:0]  strobe;
  logic [CH_N-1:0]  err_hit;
  logic [FLG_W-1:0] set_v;
  logic [CNT_W-1:0] cap_val [CH_N];

  assign act = evact_e'(cfg_evact);

  evcap_event u_event (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_in  (ev_in),
    .ev_en  (cfg_ev_en),
    .ev_inv (cfg_ev_inv),
    .rise   (rise),
    .fall   (fall)
  );

  evcap_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cfg_run),
    .act   (act),
    .rise  (rise),
    .cnt   (count_o),
    .ovf   (ovf)
  );

  // Edge routing: which edge feeds which channel for each action.
  always_comb begin
    case (act)
      ACT_STAMP: strobe = {rise, rise};
      ACT_PPW:   strobe = {fall, rise};
      ACT_PWP:   strobe = {rise, fall};
      ACT_PW:    strobe = {fall, fall};
      default:   strobe = '0;
    endcase
    strobe = strobe & cfg_cap_en;
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    evcap_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe[g]),
      .mode   (cfg_cap_mode[2*g +: 2]),
      .sample (count_o),
      .value  (cap_val[g])
    );
    assign err_hit[g] = strobe[g] & flags_o[FLG_CH0+g] & ~flag_clr[FLG_CH0+g];
  end

  assign cap0_o = cap_val[0];
  assign cap1_o = cap_val[1];

  always_comb begin
    set_v                      = '0;
    set_v[FLG_OVF]             = ovf;
    set_v[FLG_ERR]             = |err_hit;
    set_v[FLG_CH0 +: CH_N]     = strobe;
  end

  evcap_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (set_v),
    .clr_v    (flag_clr),
    .mask_set (ien_set),
    .mask_clr (ien_clr),
    .flags    (flags_o),
    .mask     (ien_o),
    .irq      (irq_o)
  );
endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_run,
  input logic [2:0]       cfg_evact,
  input logic             cfg_ev_en,
  input logic [1:0]       cfg_cap_en,
  input logic [3:0]       cfg_cap_mode,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap0_o,
  input logic [CNT_W-1:0] cap1_o,
  input logic [7:0]       flags_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run && cfg_evact == 3'd0 && count_o != MAXV)
      |=> count_o == CNT_W'($past(count_o) + 1'b1));

  p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run && cfg_evact == 3'd0 && count_o == MAXV)
      |=> (count_o == '0 && flags_o[0]));

  p_ev_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ev_en && cfg_evact == 3'd2) |=> $stable(count_o));

  p_cap0_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cap_en[0] |=> $stable(cap0_o));

  p_cap1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cap_en[1] |=> $stable(cap1_o));

  p_min_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cap_mode[1:0] == 2'd1 && flags_o[4]) |=> cap0_o <= $past(cap0_o));

  p_max_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cap_mode[3:2] == 2'd2 && flags_o[5]) |=> cap1_o >= $past(cap1_o));
endmodule

bind evcap_unit evcap_unit_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_run      (cfg_run),
  .cfg_evact    (cfg_evact),
  .cfg_ev_en    (cfg_ev_en),
  .cfg_cap_en   (cfg_cap_en),
  .cfg_cap_mode (cfg_cap_mode),
  .count_o      (count_o),
  .cap0_o       (cap0_o),
  .cap1_o       (cap1_o),
  .flags_o      (flags_o)
);

// File: tb/evcap_unit_tb_top.sv
module evcap_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int BW    = 8;
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_in = 1'b0, cfg_run = 1'b0, cfg_ev_en = 1'b0, cfg_ev_inv = 1'b0;
  logic [2:0]    cfg_evact = '0;
  logic [1:0]    cfg_cap_en = '0;
  logic [3:0]    cfg_cap_mode = '0;
  logic [7:0]    flag_clr = '0, ien_set = '0, ien_clr = '0;
  logic [BW-1:0] count_o, cap0_o, cap1_o;
  logic [7:0]    flags_o, ien_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evcap_unit #(.CNT_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .cfg_run(cfg_run),
    .cfg_evact(cfg_evact), .cfg_ev_en(cfg_ev_en), .cfg_ev_inv(cfg_ev_inv),
    .cfg_cap_en(cfg_cap_en), .cfg_cap_mode(cfg_cap_mode), .flag_clr(flag_clr),
    .ien_set(ien_set), .ien_clr(ien_clr), .count_o(count_o), .cap0_o(cap0_o),
    .cap1_o(cap1_o), .flags_o(flags_o), .ien_o(ien_o), .irq_o(irq_o)
  );

  // Reference model built from the requirements
  logic [BW-1:0] m_cnt, m_cap0, m_cap1;
  logic          m_live, m_evq, m_held0, m_held1;
  logic [7:0]    m_flags, m_ien;

  function automatic logic keep_ok(logic held, logic [1:0] md, logic [BW-1:0] s, logic [BW-1:0] v);
    if (!held) return 1'b1;
    if (md == 2'd1) return s < v;
    if (md == 2'd2) return s > v;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_cap0 = '0; m_cap1 = '0; m_live = 0; m_evq = 0;
      m_held0 = 0; m_held1 = 0; m_flags = '0; m_ien = '0;
    end else begin
      logic ev, rs, fl, waits, go, rst_c, tk, ov, s0, s1, er;
      logic [7:0] sv;
      ev    = cfg_ev_en & (ev_in ^ cfg_ev_inv);
      rs    = ev & ~m_evq;
      fl    = ~ev & m_evq;
      waits = (cfg_evact == 3'd1) || (cfg_evact == 3'd3);
      go    = cfg_run && (m_live || !waits);
      rst_c = cfg_run && rs && (cfg_evact == 3'd1 || cfg_evact >= 3'd5);
      tk    = (cfg_evact == 3'd2) ? (cfg_run && rs) : go;
      ov    = tk && !rst_c && (m_cnt == BMAX);
      case (cfg_evact)
        3'd4: begin s0 = rs; s1 = rs; end
        3'd5: begin s0 = rs; s1 = fl; end
        3'd6: begin s0 = fl; s1 = rs; end
        3'd7: begin s0 = fl; s1 = fl; end
        default: begin s0 = 0; s1 = 0; end
      endcase
      s0 = s0 & cfg_cap_en[0];
      s1 = s1 & cfg_cap_en[1];
      er = (s0 && m_flags[4] && !flag_clr[4]) || (s1 && m_flags[5] && !flag_clr[5]);
      sv = {2'b00, s1, s0, 2'b00, er, ov};
      if (s0 && keep_ok(m_held0, cfg_cap_mode[1:0], m_cnt, m_cap0)) m_cap0 = m_cnt;
      if (s1 && keep_ok(m_held1, cfg_cap_mode[3:2], m_cnt, m_cap1)) m_cap1 = m_cnt;
      if (s0) m_held0 = 1;
      if (s1) m_held1 = 1;
      m_flags = ((m_flags & ~flag_clr) | sv) & 8'h33;
      m_ien   = ((m_ien | ien_set) & ~ien_clr) & 8'h33;
      m_live  = cfg_run && (m_live || (rs && waits));
      if (rst_c)   m_cnt = '0;
      else if (tk) m_cnt = m_cnt + 1'b1;
      m_evq = ev;
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "count", count_o, m_cnt);
    chk(tag, "cap0", cap0_o, m_cap0);
    chk(tag, "cap1", cap1_o, m_cap1);
    chk(tag, "flags", flags_o, m_flags);
    chk(tag, "ien", ien_o, m_ien);
    chk(tag, "irq", irq_o, |(m_flags & m_ien));
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    cmp_all(tag);
    flag_clr = '0; ien_set = '0; ien_clr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(string tag, int hi);
    ev_in = 1'b1; cyc(tag);
    repeat (hi - 1) cyc(tag);
    ev_in = 1'b0; cyc(tag);
  endtask

  string act_tag [8] = '{"R3", "R4", "R5", "R4", "R6", "R7", "R7", "R8"};

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] c, v, vmin, vmax;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", count_o, 0); chk("R1", "cap0", cap0_o, 0);
    chk("R1", "cap1", cap1_o, 0); chk("R1", "flags", flags_o, 0);
    chk("R1", "ien", ien_o, 0); chk("R1", "irq", irq_o, 0);

    // R3 free counting and wrap
    cfg_run = 1'b1; cfg_evact = 3'd0; cfg_ev_en = 1'b1;
    c = count_o; cyc("R3");
    chk("R3", "step", count_o, BW'(c + 1'b1));
    while (count_o != BMAX) cyc("R3");
    cyc("R3");
    chk("R3", "wrap", count_o, 0); chk("R3", "ovf", flags_o[0], 1);
    flag_clr = 8'hff; cyc("R11");
    chk("R11", "cleared", flags_o, 0);

    // R7 period then width, both channel orders
    cfg_cap_en = 2'b11; cfg_cap_mode = 4'h0;
    for (int a = 5; a <= 6; a++) begin
      cfg_evact = 3'(a); repeat (3) cyc("R7");
      c = count_o; ev_in = 1'b1; cyc("R7");
      chk("R7", "period", (a == 5) ? cap0_o : cap1_o, c);
      chk("R7", "restart", count_o, 0);
      repeat (4) cyc("R7");
      c = count_o; ev_in = 1'b0; cyc("R7");
      chk("R7", "width", (a == 5) ? cap1_o : cap0_o, c);
      chk("R7", "width_val", c, 4);
    end

    // R9 disabled channel keeps value
    v = cap1_o; cfg_evact = 3'd4; cfg_cap_en = 2'b01;
    flag_clr = 8'hff; cyc("R9");
    c = count_o; ev_in = 1'b1; cyc("R6");
    chk("R6", "stamp", cap0_o, c);
    chk("R9", "hold", cap1_o, v); chk("R9", "noflag", flags_o[5], 0);
    ev_in = 1'b0; cyc("R9");

    // R10 min and max from a fresh reset
    do_reset(); cyc("R1");
    cfg_run = 1'b1; cfg_ev_en = 1'b1; cfg_evact = 3'd7; cfg_cap_en = 2'b11;
    cfg_cap_mode = 4'b1001;
    vmin = '1; vmax = '0;
    foreach (act_tag[k]) begin
      int w;
      if (k >= 3) break;
      w = (k == 0) ? 5 : (k == 1) ? 2 : 7;
      ev_in = 1'b1; cyc("R8");
      repeat (w - 1) cyc("R8");
      c = count_o; ev_in = 1'b0; cyc("R10");
      if (c < vmin) vmin = c;
      if (c > vmax) vmax = c;
      chk("R10", "min", cap0_o, vmin); chk("R10", "max", cap1_o, vmax);
      cyc("R10");
    end
    // R12 captures were never cleared: error flag set
    chk("R12", "err", flags_o[1], 1);

    // R11 capture colliding with clear: flag stays, no error
    flag_clr = 8'hff; cyc("R11");
    cfg_cap_mode = 4'h0;
    pulse("R11", 3); cyc("R11");
    chk("R11", "set", flags_o[5:4], 2'b11); chk("R12", "noerr", flags_o[1], 0);
    ev_in = 1'b1; cyc("R11"); cyc("R11");
    ev_in = 1'b0; flag_clr = 8'h30; cyc("R11");
    chk("R11", "setwins", flags_o[5:4], 2'b11); chk("R12", "cleared_no_err", flags_o[1], 0);
    chk("R11", "unused_bits", flags_o & 8'hcc, 0);

    // R13 mask set/clear and irq
    ien_set = 8'h10; cyc("R13");
    chk("R13", "mask", ien_o, 8'h10); chk("R13", "irq", irq_o, 1);
    ien_set = 8'h01; ien_clr = 8'h11; cyc("R13");
    chk("R13", "clrwins", ien_o, 0); chk("R13", "irq_off", irq_o, 0);

    // R2 and R5 gating and polarity in count mode
    cfg_evact = 3'd2; cfg_ev_en = 1'b0; cyc("R2");
    c = count_o;
    for (int i = 0; i < 6; i++) begin ev_in = ~ev_in; cyc("R2"); end
    chk("R2", "gated", count_o, c);
    ev_in = 1'b0; cyc("R2"); cfg_ev_en = 1'b1; cyc("R5");
    c = count_o;
    pulse("R5", 2); pulse("R5", 1);
    chk("R5", "two_edges", count_o, BW'(c + 2));
    cfg_ev_inv = 1'b1; cyc("R2");           // inverted idle high -> one edge
    c = count_o; ev_in = 1'b1; cyc("R2"); cyc("R2");
    chk("R2", "inv_no_edge", count_o, c);
    ev_in = 1'b0; cyc("R2");
    chk("R2", "inv_edge", count_o, BW'(c + 1));
    cfg_ev_inv = 1'b0; ev_in = 1'b0; cyc("R2");

    // R4 retrigger and start
    cfg_run = 1'b0; cfg_evact = 3'd1; cyc("R4");
    cfg_run = 1'b1; cyc("R4");
    c = count_o; cyc("R4");
    chk("R4", "wait", count_o, c);
    ev_in = 1'b1; cyc("R4");
    chk("R4", "retrig_zero", count_o, 0);
    cyc("R4"); chk("R4", "counting", count_o, 1);
    ev_in = 1'b0; cfg_run = 1'b0; cfg_evact = 3'd3; cyc("R4");
    cfg_run = 1'b1; c = count_o; cyc("R4"); cyc("R4");
    chk("R4", "start_wait", count_o, c);
    ev_in = 1'b1; cyc("R4"); cyc("R4");
    chk("R4", "start_go", count_o, BW'(c + 1));
    ev_in = 1'b0;

    // Random phase
    for (int seg = 0; seg < 48; seg++) begin
      cfg_evact    = 3'($urandom_range(0, 7));
      cfg_run      = ($urandom_range(0, 7) != 0);
      cfg_ev_en    = ($urandom_range(0, 5) != 0);
      cfg_ev_inv   = 1'($urandom_range(0, 1));
      cfg_cap_en   = 2'($urandom_range(0, 3));
      cfg_cap_mode = 4'($urandom_range(0, 15));
      for (int i = 0; i < 160; i++) begin
        if ($urandom_range(0, 5) == 0) ev_in = ~ev_in;
        if ($urandom_range(0, 9) == 0) flag_clr = 8'($urandom);
        if ($urandom_range(0, 19) == 0) ien_set = 8'($urandom);
        if ($urandom_range(0, 19) == 0) ien_clr = 8'($urandom);
        cyc(act_tag[cfg_evact]);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule